// File: doc/BRIEF.md
# Instrument Status and Service-Request Unit

This block gathers event reports from an instrument's measurement core and from its command layer and holds them in two 8-bit report registers. The status byte carries measurement-side reports and the standard event register carries bus-protocol reports. Each report register has its own 8-bit enable mask. The core signals an event with a single-cycle pulse. The matching report bit then latches until a controller clears it.

A register-access port takes one operation per cycle. It can load either enable mask, query the status byte without side effects, take a serial poll of the status byte (which clears it), or read the event register (which clears that register). An active-low service-request line is pulled low when an enabled status report is pending. This happens only if the master request bit of the service-request enable mask is also set.

Top module: `instr_status_unit`

## Requirements
- R1: Status byte layout: bit 7 ramp complete, bit 6 request summary, bit 5 event summary, bit 4 error, bit 3 alarm, bit 2 valid reading. Bits 1 and 0 always read 0. A pulse on `ramp_done_i`, `alarm_i` or `reading_ok_i` makes its bit read 1 from the next cycle.
- R2: Status bit 4 latches when any of the eight `fault_i` lines pulses. The lines are [0] current-source overload, [1] common-mode overload, [2] differential overload, [3] mixer overload, [4] resistance over, [5] resistance under, [6] temperature over and [7] temperature under.
- R3: A status query (op 2) returns the status byte and changes no bit of it.
- R4: A serial poll (op 3) returns the status byte and clears bits 7, 4, 3 and 2. A report pulse that arrives in the same cycle as the poll survives the clear.
- R5: `srq_no` is 0 exactly when enable-mask bit 6 is 1 and some status bit among 7, 5, 4, 3, 2 is 1 together with its enable-mask bit. Otherwise it is 1.
- R6: While enable-mask bit 6 is 0, status bits still latch and can still be polled, but `srq_no` stays 1.
- R7: Event register layout: bit 7 power-on, bit 5 command error, bit 4 execution error, bit 2 query error, bit 0 operation complete. Bits 6, 3 and 1 always read 0.
- R8: Status bit 5 is 1 while any event-register bit is 1 and its event-enable bit is also 1. A serial poll does not clear status bit 5. An event read (op 4) returns the event register and clears it, so status bit 5 drops on the following cycle. An event pulse that arrives in the same cycle as the read survives the clear.
- R9: Status bit 6, as read, is the live request condition at the cycle of the read. It is not a latched report.
- R10: Access operations are selected by `acc_op_i` when `acc_valid_i` is 1: 0 loads the service-request enable mask, 1 loads the event enable mask, 2 is a status query, 3 is a serial poll and 4 is an event read. A mask load stores all 8 bits of `acc_wdata_i`. For a read, `rdata_o` carries the register value from the request cycle and `rvalid_o` is 1 for exactly one cycle, the cycle after the request.
- R11: After reset both report registers and both masks are 0, `srq_no` is 1 and `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ramp_done_i | input | 1 | Ramp complete pulse |
| reading_ok_i | input | 1 | Valid reading pulse |
| alarm_i | input | 1 | Alarm pulse |
| fault_i | input | NUM_FAULT | Instrument error pulses |
| power_on_i | input | 1 | Power-on event pulse |
| cmd_err_i | input | 1 | Command error pulse |
| exec_err_i | input | 1 | Execution error pulse |
| query_err_i | input | 1 | Query error pulse |
| op_done_i | input | 1 | Operation complete pulse |
| acc_valid_i | input | 1 | Access request |
| acc_op_i | input | 3 | Access operation code |
| acc_wdata_i | input | 8 | Mask load data |
| rdata_o | output | 8 | Read data |
| rvalid_o | output | 1 | Read data valid |
| srq_no | output | 1 | Service request, active low |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. A report pulse or a mask load shows on `srq_no` after the next edge. A read request gives `rdata_o`/`rvalid_o` after the next edge, and the clear from a poll or an event read shows in any read issued in the following cycle. Stimulus is applied on falling edges. `srq_no` is compared on the next falling edge after each driver call returns. Each read pushes its expected byte into a queue, and a monitor on falling edges pops the queue and compares whenever `rvalid_o` is high, which matches the one-cycle read latency. Same-cycle pulse-versus-clear collisions are driven on purpose for both report registers.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic [2:0] {
    OP_WR_SRQ_EN = 3'd0,
    OP_WR_EVT_EN = 3'd1,
    OP_QRY_STB   = 3'd2,
    OP_POLL_STB  = 3'd3,
    OP_RD_EVT    = 3'd4
  } acc_op_e;

  // status byte positions
  localparam int unsigned STB_RAMP  = 7;
  localparam int unsigned STB_RQS   = 6;
  localparam int unsigned STB_ESUM  = 5;
  localparam int unsigned STB_ERR   = 4;
  localparam int unsigned STB_ALARM = 3;
  localparam int unsigned STB_VALID = 2;

  // event register positions
  localparam int unsigned EVT_PON = 7;
  localparam int unsigned EVT_CME = 5;
  localparam int unsigned EVT_EXE = 4;
  localparam int unsigned EVT_QYE = 2;
  localparam int unsigned EVT_OPC = 0;

  localparam logic [REG_W-1:0] STB_LATCH_MASK = 8'h9C;
  localparam logic [REG_W-1:0] STB_SUM_MASK   = 8'hBC;
  localparam logic [REG_W-1:0] EVT_IMPL_MASK  = 8'hB5;
endpackage

// File: rtl/isu_sticky_reg.sv
module isu_sticky_reg #(
  parameter int unsigned         W    = 8,
  parameter logic [W-1:0]        IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      logic q;
      // set beats clear so no report is lost
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
        else if (clr_i)    q <= 1'b0;
      end
      assign q_o[i] = q;

      // R4 R8
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> q_o[i]);
      // R4
      clr_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i[i]) |=> !q_o[i]);
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // R10
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/isu_srq_ctrl.sv
module isu_srq_ctrl #(
  parameter int unsigned  W        = 8,
  parameter logic [W-1:0] SUM_MASK = '1,
  parameter int unsigned  MASTER   = 6
) (
  input  logic [W-1:0] stb_i,
  input  logic [W-1:0] en_i,
  output logic         rqs_o,
  output logic         srq_no
);
  logic any_enabled;
  assign any_enabled = |(stb_i & en_i & SUM_MASK);
  assign rqs_o       = en_i[MASTER] & any_enabled;
  assign srq_no      = ~rqs_o;
endmodule

// File: rtl/instr_status_unit.sv
module instr_status_unit
  import isu_pkg::*;
#(
  parameter int unsigned NUM_FAULT = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ramp_done_i,
  input  logic                 reading_ok_i,
  input  logic                 alarm_i,
  input  logic [NUM_FAULT-1:0] fault_i,
  input  logic                 power_on_i,
  input  logic                 cmd_err_i,
  input  logic                 exec_err_i,
  input  logic                 query_err_i,
  input  logic                 op_done_i,
  input  logic                 acc_valid_i,
  input  logic [2:0]           acc_op_i,
  input  logic [REG_W-1:0]     acc_wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 rvalid_o,
  output logic                 srq_no
);
  acc_op_e op;
  assign op = acc_op_e'(acc_op_i);

  logic wr_srq_en, wr_evt_en, qry_stb, poll_stb, rd_evt, is_read;
  assign wr_srq_en = acc_valid_i && (op == OP_WR_SRQ_EN);
  assign wr_evt_en = acc_valid_i && (op == OP_WR_EVT_EN);
  assign qry_stb   = acc_valid_i && (op == OP_QRY_STB);
  assign poll_stb  = acc_valid_i && (op == OP_POLL_STB);
  assign rd_evt    = acc_valid_i && (op == OP_RD_EVT);
  assign is_read   = qry_stb || poll_stb || rd_evt;

  logic [REG_W-1:0] stb_set, evt_set;
  always_comb begin
    stb_set            = '0;
    stb_set[STB_RAMP]  = ramp_done_i;
    stb_set[STB_ERR]   = |fault_i;
    stb_set[STB_ALARM] = alarm_i;
    stb_set[STB_VALID] = reading_ok_i;
    evt_set            = '0;
    evt_set[EVT_PON]   = power_on_i;
    evt_set[EVT_CME]   = cmd_err_i;
    evt_set[EVT_EXE]   = exec_err_i;
    evt_set[EVT_QYE]   = query_err_i;
    evt_set[EVT_OPC]   = op_done_i;
  end

  logic [REG_W-1:0] stb_lat, evt_q, srq_en_q, evt_en_q;

  isu_sticky_reg #(.W(REG_W), .IMPL(STB_LATCH_MASK)) u_stb (
    .clk_i, .rst_ni, .set_i(stb_set), .clr_i(poll_stb), .q_o(stb_lat));

  isu_sticky_reg #(.W(REG_W), .IMPL(EVT_IMPL_MASK)) u_evt (
    .clk_i, .rst_ni, .set_i(evt_set), .clr_i(rd_evt), .q_o(evt_q));

  isu_mask_reg #(.W(REG_W)) u_srq_en (
    .clk_i, .rst_ni, .we_i(wr_srq_en), .d_i(acc_wdata_i), .q_o(srq_en_q));

  isu_mask_reg #(.W(REG_W)) u_evt_en (
    .clk_i, .rst_ni, .we_i(wr_evt_en), .d_i(acc_wdata_i), .q_o(evt_en_q));

  logic             evt_sum, rqs;
  logic [REG_W-1:0] stb_view, stb_full;
  assign evt_sum = |(evt_q & evt_en_q);

  always_comb begin
    stb_view           = stb_lat;
    stb_view[STB_ESUM] = evt_sum;
  end

  isu_srq_ctrl #(.W(REG_W), .SUM_MASK(STB_SUM_MASK), .MASTER(STB_RQS)) u_srq (
    .stb_i(stb_view), .en_i(srq_en_q), .rqs_o(rqs), .srq_no(srq_no));

  always_comb begin
    stb_full          = stb_view;
    stb_full[STB_RQS] = rqs;
  end

  // read port: one-cycle latency, value captured before any clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= is_read;
      if (is_read) rdata_o <= rd_evt ? evt_q : stb_full;
    end
  end

  // R6
  srq_master_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srq_en_q[STB_RQS] |-> srq_no);
  // R8
  esum_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt && !(|evt_set) && !wr_evt_en) |=> !stb_view[STB_ESUM]);
  // R10
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(is_read));
  // R1
  stb_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !$past(rd_evt)) |-> (rdata_o[1:0] == 2'b00));
  // R9
  rqs_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !$past(rd_evt)) |-> (rdata_o[STB_RQS] == !$past(srq_no)));
endmodule

// File: tb/sim_instr_status_unit.sv
module sim_instr_status_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ramp = 0, rok = 0, alm = 0, pon = 0, cme = 0, exe = 0, qye = 0, opc = 0;
  logic [7:0] flt = '0;
  logic       acc_v = 0;
  logic [2:0] acc_op = '0;
  logic [7:0] acc_wd = '0;
  logic [7:0] rdata;
  logic       rvalid, srq_n;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #5 clk = ~clk;

  instr_status_unit #(.NUM_FAULT(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ramp_done_i(ramp), .reading_ok_i(rok),
    .alarm_i(alm), .fault_i(flt), .power_on_i(pon), .cmd_err_i(cme),
    .exec_err_i(exe), .query_err_i(qye), .op_done_i(opc),
    .acc_valid_i(acc_v), .acc_op_i(acc_op), .acc_wdata_i(acc_wd),
    .rdata_o(rdata), .rvalid_o(rvalid), .srq_no(srq_n));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads as they appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk(rdata, 8'hxx, "R10 unexpected rvalid");
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        chk(rdata, e, t);
      end
    end
  end

  // driver: called at a negedge, returns at the next negedge
  task automatic acc(input logic [2:0] op, input logic [7:0] wd,
                     input logic [7:0] exp, input string tag);
    acc_v = 1; acc_op = op; acc_wd = wd;
    if (op >= 3'd2) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    acc_v = 0;
  endtask

  task automatic idle();
    ramp = 0; rok = 0; alm = 0; flt = '0; pon = 0; cme = 0; exe = 0; qye = 0; opc = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic srq_chk(input logic exp, input string tag);
    chk({7'd0, srq_n}, {7'd0, exp}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({7'd0, srq_n}, 8'h01, "R11 srq_no at reset");
    chk({7'd0, rvalid}, 8'h00, "R11 rvalid at reset");
    rst_n = 1;
    @(negedge clk);
    acc(3'd2, 0, 8'h00, "R11 status after reset");
    acc(3'd4, 0, 8'h00, "R11 events after reset");

    rok = 1; step();
    acc(3'd2, 0, 8'h04, "R1 valid reading bit 2");
    acc(3'd2, 0, 8'h04, "R3 query keeps bits");
    ramp = 1; alm = 1; step();
    acc(3'd2, 0, 8'h8C, "R1 ramp and alarm bits");
    acc(3'd3, 0, 8'h8C, "R4 poll returns value");
    acc(3'd2, 0, 8'h00, "R4 poll cleared bits");

    for (int i = 0; i < 8; i++) begin
      flt[i] = 1'b1; step();
      acc(3'd3, 0, 8'h10, $sformatf("R2 fault line %0d", i));
    end
    acc(3'd2, 0, 8'h00, "R2 error cleared");

    acc(3'd0, 8'h08, 0, "");
    alm = 1; step();
    srq_chk(1'b1, "R6 master clear keeps srq high");
    acc(3'd2, 0, 8'h08, "R6 bit still latched");
    acc(3'd0, 8'h48, 0, "");
    srq_chk(1'b0, "R5 enabled alarm requests");
    acc(3'd2, 0, 8'h48, "R9 bit 6 live in query");
    acc(3'd3, 0, 8'h48, "R9 bit 6 in poll");
    srq_chk(1'b1, "R5 released after poll");
    acc(3'd0, 8'h50, 0, "");
    alm = 1; step();
    srq_chk(1'b1, "R5 unenabled alarm no request");
    acc(3'd3, 0, 8'h08, "R5 poll alarm");

    pon = 1; cme = 1; exe = 1; qye = 1; opc = 1; step();
    acc(3'd4, 0, 8'hB5, "R7 event layout");
    acc(3'd4, 0, 8'h00, "R7 read cleared events");
    cme = 1; step();
    acc(3'd4, 0, 8'h20, "R7 command error bit 5");

    acc(3'd1, 8'h20, 0, "");
    acc(3'd0, 8'h60, 0, "");
    cme = 1; step();
    srq_chk(1'b0, "R8 event summary requests");
    acc(3'd2, 0, 8'h60, "R8 summary and request bits");
    acc(3'd4, 0, 8'h20, "R8 event read");
    srq_chk(1'b1, "R8 summary drops after read");
    acc(3'd2, 0, 8'h00, "R8 summary cleared");
    acc(3'd1, 8'h01, 0, "");
    cme = 1; step();
    acc(3'd2, 0, 8'h00, "R8 masked event no summary");
    acc(3'd4, 0, 8'h20, "R8 masked event still latched");

    alm = 1; step();
    rok = 1; acc(3'd3, 0, 8'h08, "R4 poll with same-cycle pulse"); idle();
    acc(3'd2, 0, 8'h04, "R4 same-cycle pulse kept");
    acc(3'd3, 0, 8'h04, "R4 clear");
    opc = 1; step();
    opc = 1; acc(3'd4, 0, 8'h01, "R8 read with same-cycle pulse"); idle();
    acc(3'd4, 0, 8'h01, "R8 same-cycle event kept");

    acc(3'd0, 8'h00, 0, "");
    acc(3'd1, 8'h20, 0, "");
    cme = 1; step();
    acc(3'd3, 0, 8'h20, "R8 poll shows summary");
    acc(3'd2, 0, 8'h20, "R8 poll leaves summary");
    acc(3'd4, 0, 8'h20, "R8 event read");
    acc(3'd2, 0, 8'h00, "R8 summary gone");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "R10 reads outstanding");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule